// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Controller

This peripheral gives software control of a bank of general-purpose pins through a small window of memory-mapped registers on a simple synchronous register bus. Each pin has a three-bit mode field. The mode fields are packed ten to a 32-bit select word, and the mode sets whether the pin's output driver is enabled. Output levels change only through two write-only strobe registers. A one written to a raise word drives the matching pin high. A one written to a lower word drives it low. A zero in either word does nothing, so software never has to read, modify and write the output state.

A level word reads back the pin inputs after a two-flop synchroniser. Read data is registered and appears one clock after a read is sampled. The window decodes only when the upper address bits match a fixed base of 0xFE200000. Every other address, and every unused offset inside the window, reads as zero and ignores writes.

Top module: `gpio_mmio_ctrl`

## Requirements
- R1: An access whose address bits [31:8] differ from those of 0xFE200000 writes nothing, and a read of it returns zero.
- R2: Pin n has its mode field in select word n/10, at window offset 4*(n/10) inside 0x00..0x14, bits [3*(n%10)+2 : 3*(n%10)]. A written field reads back unchanged. Bits 31:30, and the fields of pins at or above the pin count, read as zero.
- R3: From the clock edge that samples a select write onward, pin_oe[n] is 1 when the pin's field is 001. It is 0 for 000 (input) and for every other code (alternate function).
- R4: Writing a 1 to bit b of raise word k (offset 0x1C for k=0, 0x20 for k=1) sets pin_out[32k+b] to 1 at the clock edge that samples the write.
- R5: Writing a 1 to bit b of lower word k (offset 0x28 for k=0, 0x2C for k=1) clears pin_out[32k+b] at the clock edge that samples the write.
- R6: Zero bits in a raise or lower write leave the matching outputs unchanged. Both the raise and the lower words read as zero.
- R7: Level word k (offset 0x34 for k=0, 0x38 for k=1) returns bit b = synchronised pin_in[32k+b]. A pin change set up before edge E is returned by a read sampled at edge E+2 and not by one sampled at edge E+1.
- R8: bus_rdata changes only at an edge that samples bus_rd, and takes the addressed value there. Unused offsets inside the window (0x18, 0x24, 0x30, 0x3C and above) read as zero and ignore writes.
- R9: After reset every mode field is 000, every output latch is 0, pin_oe is all zero and bus_rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Output latch value per pin |
| pin_oe | output | NUM_PINS | Output driver enable per pin |

## Verification
Mode, raise and lower writes affect pin_oe and pin_out at the same edge that samples the write. The bench therefore compares pin state at the falling edge right after each write. Read data is due one edge after the sampled read. The driver pushes each expected word into a queue, and a monitor pops and compares one entry at the falling edge after every sampled read. The input path is due two edges after a pin change. Two back-to-back reads expect the old level and then the new one.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   typedef enum logic [2:0] {
      RK_NONE,
      RK_MODE,
      RK_RAISE,
      RK_LOWER,
      RK_LEVEL
   } reg_kind_e;

   typedef struct packed {
      reg_kind_e  kind;
      logic [2:0] idx;
   } reg_dec_t;

   localparam logic [2:0] MODE_INPUT  = 3'b000;
   localparam logic [2:0] MODE_OUTPUT = 3'b001;

   localparam int PINS_PER_WORD = 10;
   localparam int PINS_PER_BANK = 32;
   localparam int MAX_MODE_WORDS = 6;
   localparam int MAX_BANKS      = 2;

   localparam int MODE_WORD0  = 0;
   localparam int RAISE_WORD0 = 7;
   localparam int LOWER_WORD0 = 10;
   localparam int LEVEL_WORD0 = 13;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
   import gpio_pkg::*;
#(
   parameter logic [31:0] BASE_ADDR  = 32'hFE20_0000,
   parameter int          MODE_WORDS = 6,
   parameter int          BANKS      = 2
) (
   input  logic [31:0] addr,
   output reg_dec_t    dec
);
   localparam int WORD_W = 6;

   logic              in_window;
   logic [WORD_W-1:0] word;

   assign in_window = (addr[31:8] == BASE_ADDR[31:8]);
   assign word      = addr[7:2];

   always_comb begin
      dec.kind = RK_NONE;
      dec.idx  = '0;
      if (in_window) begin
         if (word < WORD_W'(MODE_WORD0 + MODE_WORDS)) begin
            dec.kind = RK_MODE;
            dec.idx  = 3'(word - WORD_W'(MODE_WORD0));
         end else if (word >= WORD_W'(RAISE_WORD0) &&
                      word <  WORD_W'(RAISE_WORD0 + BANKS)) begin
            dec.kind = RK_RAISE;
            dec.idx  = 3'(word - WORD_W'(RAISE_WORD0));
         end else if (word >= WORD_W'(LOWER_WORD0) &&
                      word <  WORD_W'(LOWER_WORD0 + BANKS)) begin
            dec.kind = RK_LOWER;
            dec.idx  = 3'(word - WORD_W'(LOWER_WORD0));
         end else if (word >= WORD_W'(LEVEL_WORD0) &&
                      word <  WORD_W'(LEVEL_WORD0 + BANKS)) begin
            dec.kind = RK_LEVEL;
            dec.idx  = 3'(word - WORD_W'(LEVEL_WORD0));
         end
      end
   end
endmodule

// File: rtl/gpio_mode_bank.sv
module gpio_mode_bank
   import gpio_pkg::*;
#(
   parameter int NUM_PINS   = 54,
   parameter int MODE_WORDS = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [2:0]               idx,
   input  logic [31:0]              wdata,
   output logic [MODE_WORDS*32-1:0] word_rd,
   output logic [NUM_PINS-1:0]      oe
);
   logic [3*NUM_PINS-1:0] mode_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= '0;
      end else if (we) begin
         for (int n = 0; n < NUM_PINS; n++) begin
            if (idx == 3'(n / PINS_PER_WORD))
               mode_q[3*n +: 3] <= wdata[3*(n % PINS_PER_WORD) +: 3];
         end
      end
   end

   for (genvar w = 0; w < MODE_WORDS; w++) begin : g_word
      assign word_rd[32*w+30 +: 2] = 2'b00;
      for (genvar p = 0; p < PINS_PER_WORD; p++) begin : g_slot
         if (w*PINS_PER_WORD + p < NUM_PINS) begin : g_live
            assign word_rd[32*w+3*p +: 3] = mode_q[3*(w*PINS_PER_WORD+p) +: 3];
         end else begin : g_empty
            assign word_rd[32*w+3*p +: 3] = 3'b000;
         end
      end
   end

   for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
      localparam int W = n / PINS_PER_WORD;
      localparam int L = 3 * (n % PINS_PER_WORD);

      assign oe[n] = (mode_q[3*n +: 3] == MODE_OUTPUT);

      // R3: an output code enables the driver from the next edge
      a_r3_output_enables: assert property (@(posedge clk) disable iff (!rst_n)
         (we && idx == 3'(W) && wdata[L +: 3] == MODE_OUTPUT) |=> oe[n]);

      // R3: input and alternate codes disable the driver
      a_r3_other_disables: assert property (@(posedge clk) disable iff (!rst_n)
         (we && idx == 3'(W) && wdata[L +: 3] != MODE_OUTPUT) |=> !oe[n]);
   end
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
   parameter int NUM_PINS = 54
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] raise_mask,
   input  logic [NUM_PINS-1:0] lower_mask,
   output logic [NUM_PINS-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= (q | raise_mask) & ~lower_mask;
   end

   for (genvar n = 0; n < NUM_PINS; n++) begin : g_chk
      // R4: a raise bit without a lower bit drives the pin high
      a_r4_raise_high: assert property (@(posedge clk) disable iff (!rst_n)
         (raise_mask[n] && !lower_mask[n]) |=> q[n]);

      // R5: a lower bit drives the pin low and wins over a raise bit
      a_r5_lower_low: assert property (@(posedge clk) disable iff (!rst_n)
         lower_mask[n] |=> !q[n]);

      // R6: no strobe bit leaves the latch alone
      a_r6_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
         (!raise_mask[n] && !lower_mask[n]) |=> $stable(q[n]));
   end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int NUM_PINS = 54,
   parameter int STAGES   = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] d,
   output logic [NUM_PINS-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_in_sync: STAGES must be at least 2");
   end

   logic [NUM_PINS-1:0] stage_q [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= d;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign q = stage_q[STAGES-1];

   if (STAGES == 2) begin : g_chk2
      logic [1:0] armed_cnt;
      always_ff @(posedge clk) begin
         if (!rst_n)                 armed_cnt <= '0;
         else if (armed_cnt != 2'd3) armed_cnt <= armed_cnt + 2'd1;
      end

      // R7: the synchronised level trails the pin by two edges
      a_r7_two_flop_delay: assert property (@(posedge clk) disable iff (!rst_n)
         (armed_cnt >= 2'd2) |-> (q == $past(d, 2)));
   end
endmodule

// File: rtl/gpio_mmio_ctrl.sv
module gpio_mmio_ctrl
   import gpio_pkg::*;
#(
   parameter logic [31:0] BASE_ADDR   = 32'hFE20_0000,
   parameter int          NUM_PINS    = 54,
   parameter int          SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [31:0]         bus_addr,
   input  logic                bus_we,
   input  logic                bus_rd,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe
);
   localparam int MODE_WORDS = (NUM_PINS + PINS_PER_WORD - 1) / PINS_PER_WORD;
   localparam int BANKS      = (NUM_PINS + PINS_PER_BANK - 1) / PINS_PER_BANK;

   if (NUM_PINS < 1 || MODE_WORDS > MAX_MODE_WORDS || BANKS > MAX_BANKS) begin : g_bad_pins
      $error("gpio_mmio_ctrl: NUM_PINS must lie in 1..60");
   end
   if (BASE_ADDR[7:0] != 8'h00) begin : g_bad_base
      $error("gpio_mmio_ctrl: BASE_ADDR must be 256-byte aligned");
   end

   reg_dec_t dec;

   gpio_addr_dec #(
      .BASE_ADDR (BASE_ADDR),
      .MODE_WORDS(MODE_WORDS),
      .BANKS     (BANKS)
   ) dec_i (
      .addr(bus_addr),
      .dec (dec)
   );

   logic mode_we, raise_we, lower_we;
   assign mode_we  = bus_we && (dec.kind == RK_MODE);
   assign raise_we = bus_we && (dec.kind == RK_RAISE);
   assign lower_we = bus_we && (dec.kind == RK_LOWER);

   logic [MODE_WORDS*32-1:0] mode_rd;

   gpio_mode_bank #(
      .NUM_PINS  (NUM_PINS),
      .MODE_WORDS(MODE_WORDS)
   ) mode_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (mode_we),
      .idx    (dec.idx),
      .wdata  (bus_wdata),
      .word_rd(mode_rd),
      .oe     (pin_oe)
   );

   logic [NUM_PINS-1:0] raise_mask, lower_mask;

   for (genvar n = 0; n < NUM_PINS; n++) begin : g_mask
      assign raise_mask[n] = raise_we && (dec.idx == 3'(n / PINS_PER_BANK))
                             && bus_wdata[n % PINS_PER_BANK];
      assign lower_mask[n] = lower_we && (dec.idx == 3'(n / PINS_PER_BANK))
                             && bus_wdata[n % PINS_PER_BANK];
   end

   gpio_out_latch #(
      .NUM_PINS(NUM_PINS)
   ) latch_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .raise_mask(raise_mask),
      .lower_mask(lower_mask),
      .q         (pin_out)
   );

   logic [NUM_PINS-1:0] level_q;

   gpio_in_sync #(
      .NUM_PINS(NUM_PINS),
      .STAGES  (SYNC_STAGES)
   ) sync_i (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pin_in),
      .q    (level_q)
   );

   logic [BANKS*32-1:0] level_rd;

   for (genvar b = 0; b < BANKS*32; b++) begin : g_level
      if (b < NUM_PINS) begin : g_live
         assign level_rd[b] = level_q[b];
      end else begin : g_empty
         assign level_rd[b] = 1'b0;
      end
   end

   logic [31:0] rd_val;

   always_comb begin
      rd_val = '0;
      case (dec.kind)
         RK_MODE: begin
            for (int w = 0; w < MODE_WORDS; w++)
               if (dec.idx == 3'(w)) rd_val = mode_rd[32*w +: 32];
         end
         RK_LEVEL: begin
            for (int k = 0; k < BANKS; k++)
               if (dec.idx == 3'(k)) rd_val = level_rd[32*k +: 32];
         end
         default: rd_val = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_val;
   end

   // R6: strobe registers read back as zero
   a_r6_strobe_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && (dec.kind == RK_RAISE || dec.kind == RK_LOWER)) |=> (bus_rdata == '0));

   // R1: reads outside the window return zero
   a_r1_outside_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr[31:8] != BASE_ADDR[31:8]) |=> (bus_rdata == '0));

   // R8: unused offsets read as zero
   a_r8_unused_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && dec.kind == RK_NONE) |=> (bus_rdata == '0));

   // R8: read data holds between reads
   a_r8_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/gpio_mmio_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_mmio_ctrl_tb_top;
   localparam int          NP   = 54;
   localparam logic [31:0] BASE = 32'hFE20_0000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [31:0]   bus_addr = '0;
   logic          bus_we = 1'b0;
   logic          bus_rd = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_out;
   logic [NP-1:0] pin_oe;

   always #4 clk = ~clk;

   gpio_mmio_ctrl #(.BASE_ADDR(BASE), .NUM_PINS(NP)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   typedef struct {
      logic [31:0] exp;
      string       req;
   } sb_item_t;

   sb_item_t sb[$];
   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [2:0]    m_mode [NP];
   logic [NP-1:0] m_out = '0;

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [NP-1:0] m_oe();
      logic [NP-1:0] r = '0;
      for (int n = 0; n < NP; n++) r[n] = (m_mode[n] == 3'b001);
      return r;
   endfunction

   function automatic logic [31:0] mode_word(int w);
      logic [31:0] r = '0;
      for (int p = 0; p < 10; p++)
         if (10*w + p < NP) r[3*p +: 3] = m_mode[10*w + p];
      return r;
   endfunction

   function automatic logic [31:0] level_word(int k);
      logic [31:0] r = '0;
      for (int b = 0; b < 32; b++)
         if (32*k + b < NP) r[b] = pin_in[32*k + b];
      return r;
   endfunction

   function automatic void m_mode_wr(int w, logic [31:0] d);
      for (int p = 0; p < 10; p++)
         if (10*w + p < NP) m_mode[10*w + p] = d[3*p +: 3];
   endfunction

   function automatic void m_strobe(int k, logic [31:0] d, bit raise);
      for (int b = 0; b < 32; b++)
         if (32*k + b < NP && d[b]) m_out[32*k + b] = raise;
   endfunction

   // Driver: called at a falling edge, returns at the falling edge after the write
   task automatic wr(logic [31:0] addr, logic [31:0] data);
      bus_addr = addr; bus_wdata = data; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(logic [31:0] addr, logic [31:0] exp, string req);
      sb_item_t it;
      it.exp = exp; it.req = req;
      sb.push_back(it);
      bus_addr = addr; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic check_pins(string req);
      check({req, " pin_out"}, 64'(pin_out), 64'(m_out));
      check({req, " pin_oe"},  64'(pin_oe),  64'(m_oe()));
   endtask

   // Monitor: compare read data one edge after each sampled read
   logic rd_seen = 1'b0;
   always @(posedge clk) rd_seen <= rst_n && bus_rd;

   always @(negedge clk) begin
      if (rd_seen) begin
         if (sb.size() == 0) begin
            n_checks++; n_fail++;
            $display("FAIL R8: read data %h with no expected item", bus_rdata);
         end else begin
            sb_item_t it;
            it = sb.pop_front();
            check(it.req, 64'(bus_rdata), 64'(it.exp));
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [NP-1:0] pat;
      logic [31:0]   old_lo;
      for (int n = 0; n < NP; n++) m_mode[n] = 3'b000;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R9: reset state
      check("R9 pin_out", 64'(pin_out), 64'(0));
      check("R9 pin_oe", 64'(pin_oe), 64'(0));
      check("R9 rdata", 64'(bus_rdata), 64'(0));
      rd(BASE + 32'h04, 32'h0, "R9 mode word 1 after reset");

      // R2/R3: pin 17 as output (word 1, bits 23:21)
      wr(BASE + 32'h04, 32'h0020_0000); m_mode_wr(1, 32'h0020_0000);
      check_pins("R3 pin17 output");
      rd(BASE + 32'h04, mode_word(1), "R2 word 1 readback");

      // R2/R3: all-ones codes are alternate functions, bits 31:30 read zero
      wr(BASE + 32'h00, 32'hFFFF_FFFF); m_mode_wr(0, 32'hFFFF_FFFF);
      check_pins("R3 alternate codes disable driver");
      rd(BASE + 32'h00, 32'h3FFF_FFFF, "R2 word 0 top bits zero");

      // R2: last word holds only pins 50..53
      wr(BASE + 32'h14, 32'hFFFF_FFFF); m_mode_wr(5, 32'hFFFF_FFFF);
      rd(BASE + 32'h14, 32'h0000_0FFF, "R2 absent pins read zero");
      wr(BASE + 32'h14, 32'h0000_0249); m_mode_wr(5, 32'h0000_0249);
      check_pins("R3 pins 50..53 output");

      // R3: pin0 alternate, pin1 output, rest input
      wr(BASE + 32'h00, 32'h0000_000A); m_mode_wr(0, 32'h0000_000A);
      check_pins("R3 mixed codes");

      // R4: raise pins
      wr(BASE + 32'h1C, 32'h0002_0000); m_strobe(0, 32'h0002_0000, 1);
      check_pins("R4 raise pin 17");
      wr(BASE + 32'h20, 32'h0020_0008); m_strobe(1, 32'h0020_0008, 1);
      check_pins("R4 raise pins 35 and 53");

      // R6: zero writes change nothing, strobe words read zero
      wr(BASE + 32'h1C, 32'h0); wr(BASE + 32'h28, 32'h0); wr(BASE + 32'h2C, 32'h0);
      check_pins("R6 zero strobes hold");
      rd(BASE + 32'h1C, 32'h0, "R6 raise word reads zero");
      rd(BASE + 32'h2C, 32'h0, "R6 lower word reads zero");

      // R5: lower pins
      wr(BASE + 32'h28, 32'h0002_0000); m_strobe(0, 32'h0002_0000, 0);
      check_pins("R5 lower pin 17");
      wr(BASE + 32'h2C, 32'h0020_0000); m_strobe(1, 32'h0020_0000, 0);
      check_pins("R5 lower pin 53");
      wr(BASE + 32'h1C, 32'hFFFF_FFFF); m_strobe(0, 32'hFFFF_FFFF, 1);
      wr(BASE + 32'h20, 32'hFFFF_FFFF); m_strobe(1, 32'hFFFF_FFFF, 1);
      check_pins("R4 raise all");
      wr(BASE + 32'h28, 32'h0000_FFFF); m_strobe(0, 32'h0000_FFFF, 0);
      check_pins("R5 lower low half");

      // R8: unused offsets ignore writes and read zero
      wr(BASE + 32'h18, 32'hFFFF_FFFF);
      wr(BASE + 32'h24, 32'hFFFF_FFFF);
      wr(BASE + 32'h30, 32'hFFFF_FFFF);
      wr(BASE + 32'h3C, 32'hFFFF_FFFF);
      check_pins("R8 unused writes ignored");
      rd(BASE + 32'h18, 32'h0, "R8 offset 0x18 reads zero");
      rd(BASE + 32'h24, 32'h0, "R8 offset 0x24 reads zero");
      rd(BASE + 32'h00, mode_word(0), "R8 mode word 0 untouched");

      // R1: outside the window
      wr(32'hFE30_0004, 32'hFFFF_FFFF);
      wr(32'hFE30_0028, 32'hFFFF_FFFF);
      check_pins("R1 outside writes ignored");
      rd(BASE + 32'h04, mode_word(1), "R1 word 1 untouched");
      rd(32'hFE30_0004, 32'h0, "R1 outside read zero");

      // R7: level words
      pat = 54'h2A_5C3F_0F96_E1B4;
      pin_in = pat;
      repeat (3) @(negedge clk);
      rd(BASE + 32'h34, level_word(0), "R7 level word 0");
      rd(BASE + 32'h38, level_word(1), "R7 level word 1");

      // R7: two-edge synchroniser latency
      old_lo = level_word(0);
      pin_in = ~pat;
      @(negedge clk);
      rd(BASE + 32'h34, old_lo, "R7 one edge after change still old");
      rd(BASE + 32'h34, level_word(0), "R7 two edges after change new");

      // R8: read data holds while idle
      repeat (3) @(negedge clk);
      check("R8 rdata holds", 64'(bus_rdata), 64'(level_word(0)));

      repeat (2) @(negedge clk);
      check("R8 scoreboard drained", 64'(sb.size()), 64'(0));
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule